// File: doc/BRIEF.md
# Byte-Wide Accumulator Processor

A compact multi-cycle processor built around an 8-bit accumulator and one general register. It reads its program from an external byte-wide memory through an 8-bit address output and one shared bidirectional data bus. A chip-select strobe and separate read and write strobes control each bus access. Instructions are one or two bytes long. The second byte, when present, is either a memory address or a jump target.

Each bus access takes one clock. The memory is expected to answer a read in the same cycle. Fetching an opcode costs one cycle, and a register-only instruction executes within that cycle. A jump costs one more cycle to read its target. A load or store costs two more cycles: one for the operand byte and one for the data access. After the halt opcode the processor leaves the bus idle until reset is asserted again.

Top module: `acc8_core`

## Requirements
- R1: While `rst_n` is low, `cs_o`, `rd_o` and `wr_o` are all low. In the first cycle after `rst_n` rises, the processor reads the opcode at address 0x00. The accumulator, the general register and the zero flag reset to 0.
- R2: An opcode fetch is one cycle with `cs_o` and `rd_o` high and `addr_o` equal to the program counter. The program counter then advances by one, wrapping from 0xFF to 0x00.
- R3: Opcode 0x00 (load) reads the operand byte at PC+1. In the next cycle it reads the byte at that operand address and places it in the accumulator.
- R4: Opcode 0x08 (store) reads the operand byte. In the next cycle it raises `wr_o` with `addr_o` equal to the operand and drives the accumulator onto `data_io`.
- R5: Opcode 0x11 copies the accumulator into the general register in one cycle.
- R6: Opcode 0x29 replaces the accumulator with the accumulator minus the general register, modulo 256, in one cycle.
- R7: Opcode 0x40 replaces the accumulator with accumulator AND register. Opcode 0x41 replaces it with accumulator XOR register. Each takes one cycle.
- R8: The zero flag is written only by 0x29, 0x40 and 0x41. It is set exactly when their 8-bit result is 0x00. Loads, stores, 0x11 and jumps leave it unchanged.
- R9: Opcode 0x60 reads its operand byte, and the next fetch is from that address.
- R10: Opcode 0x68 reads its operand byte. The next fetch is from that address when the zero flag is clear; otherwise it is from the address after the operand.
- R11: Opcode 0xF8 stops execution. From then on `cs_o`, `rd_o` and `wr_o` stay low until reset.
- R12: Any other opcode is a one-byte, one-cycle no-operation.
- R13: `cs_o` is high exactly when `rd_o` or `wr_o` is high, and `rd_o` and `wr_o` are never high together. `data_io` is driven by the processor only while `wr_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| data_io | inout | 8 | Shared data bus; driven by the processor only during writes |
| addr_o | output | 8 | Memory address of the current access |
| cs_o | output | 1 | Chip select, high for every read or write cycle |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |

## Verification
The first program mixes every defined opcode with data values chosen so that subtract, AND and XOR give distinct results. A wrong operator or operand order therefore shows up in the bytes written back. The jump-if-not-zero instruction is placed once after a zero result and once after a non-zero result, which separates the taken path from the fall-through path. A second program makes the zero flag from XOR, then runs loads, a register move and a store before testing the flag, which exposes any instruction that disturbs the flag when it should not. The same program also drives a subtraction below zero, runs undefined opcodes at the top of the address space and lets the program counter wrap to 0x00. A third run asserts reset in the middle of execution and checks that fetching restarts cleanly from address 0x00.

// File: rtl/acc8_core.sv
module acc8_core #(
  parameter logic [7:0] START_PC = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  inout  wire  [7:0] data_io,
  output logic [7:0] addr_o,
  output logic       cs_o,
  output logic       rd_o,
  output logic       wr_o
);
  localparam logic [7:0] OP_LD  = 8'h00;
  localparam logic [7:0] OP_ST  = 8'h08;
  localparam logic [7:0] OP_MOV = 8'h11;
  localparam logic [7:0] OP_SUB = 8'h29;
  localparam logic [7:0] OP_AND = 8'h40;
  localparam logic [7:0] OP_XOR = 8'h41;
  localparam logic [7:0] OP_JMP = 8'h60;
  localparam logic [7:0] OP_JNZ = 8'h68;
  localparam logic [7:0] OP_HLT = 8'hF8;

  typedef enum logic [1:0] {S_FETCH, S_OPND, S_MEM, S_HALT} state_t;

  state_t     state_q;
  logic [7:0] pc_q, ir_q, opa_q, ac_q, gr_q;
  logic       zf_q;
  logic [7:0] alu_res;

  assign rd_o    = rst_n && (state_q == S_FETCH || state_q == S_OPND ||
                             (state_q == S_MEM && ir_q == OP_LD));
  assign wr_o    = rst_n && state_q == S_MEM && ir_q == OP_ST;
  assign cs_o    = rd_o || wr_o;
  assign addr_o  = (state_q == S_MEM) ? opa_q : pc_q;
  assign data_io = wr_o ? ac_q : 8'hzz;

  always_comb begin
    case (data_io)
      OP_SUB:  alu_res = ac_q - gr_q;
      OP_AND:  alu_res = ac_q & gr_q;
      default: alu_res = ac_q ^ gr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_FETCH;
      pc_q    <= START_PC;
      ir_q    <= 8'h00;
      opa_q   <= 8'h00;
      ac_q    <= 8'h00;
      gr_q    <= 8'h00;
      zf_q    <= 1'b0;
    end else begin
      case (state_q)
        S_FETCH: begin
          ir_q <= data_io;
          pc_q <= pc_q + 8'd1;
          case (data_io)
            OP_LD, OP_ST, OP_JMP, OP_JNZ: state_q <= S_OPND;
            OP_MOV: gr_q <= ac_q;
            OP_SUB, OP_AND, OP_XOR: begin
              ac_q <= alu_res;
              zf_q <= (alu_res == 8'h00);
            end
            OP_HLT: state_q <= S_HALT;
            default: ;
          endcase
        end
        S_OPND: begin
          opa_q <= data_io;
          case (ir_q)
            OP_JMP: begin
              pc_q    <= data_io;
              state_q <= S_FETCH;
            end
            OP_JNZ: begin
              pc_q    <= zf_q ? pc_q + 8'd1 : data_io;
              state_q <= S_FETCH;
            end
            default: begin
              pc_q    <= pc_q + 8'd1;
              state_q <= S_MEM;
            end
          endcase
        end
        S_MEM: begin
          if (ir_q == OP_LD) ac_q <= data_io;
          state_q <= S_FETCH;
        end
        default: state_q <= S_HALT;
      endcase
    end
  end
endmodule

module acc8_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] addr_o,
  input logic       cs_o,
  input logic       rd_o,
  input logic       wr_o
);
  a_r13_cs_matches_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    cs_o == (rd_o || wr_o));
  a_r13_no_rd_with_wr: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_o && wr_o));
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |-> (!cs_o && !rd_o && !wr_o));
  a_r1_first_fetch_zero: assert property (@(posedge clk)
    (rst_n && $past(rst_n) == 1'b0) |-> (rd_o && addr_o == 8'h00));
  a_r11_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_o |=> !cs_o);
  a_r4_write_after_operand: assert property (@(posedge clk) disable iff (!rst_n)
    wr_o |-> $past(rd_o));
endmodule

bind acc8_core acc8_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr_o(addr_o),
  .cs_o(cs_o), .rd_o(rd_o), .wr_o(wr_o)
);

// File: tb/acc8_core_bench.sv
`timescale 1ns/1ps
module acc8_core_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  wire  [7:0] bus;
  logic [7:0] addr;
  logic       cs, rd, wr;
  logic [7:0] mem [256];
  logic [7:0] mm  [256];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    bit         r;
    bit         w;
    logic [7:0] a;
    logic [7:0] d;
    string      t;
  } cyc_t;
  cyc_t exp_q[$];

  always #2 clk = ~clk;

  acc8_core u_acc8_core (
    .clk(clk), .rst_n(rst_n), .data_io(bus), .addr_o(addr),
    .cs_o(cs), .rd_o(rd), .wr_o(wr)
  );

  assign bus = (cs && rd) ? mem[addr] : 8'hzz;
  always @(posedge clk) if (cs && wr) mem[addr] <= bus;

  task automatic cmp(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(bit r, bit w, logic [7:0] a, logic [7:0] d, string t);
    cyc_t c;
    c.r = r; c.w = w; c.a = a; c.d = d; c.t = t;
    exp_q.push_back(c);
  endtask

  task automatic build(int n);
    logic [7:0] pc = 0, ac = 0, gr = 0, op, a;
    bit z = 0, h = 0;
    string ltag = "R3";
    string nt = "R1";
    for (int i = 0; i < 256; i++) mm[i] = mem[i];
    exp_q.delete();
    while (exp_q.size() < n) begin
      if (h) begin
        push(0, 0, 0, 0, "R11");
        continue;
      end
      op = mm[pc];
      push(1, 0, pc, 0, nt);
      pc = pc + 1;
      nt = "R2";
      case (op)
        8'h00: begin
          a = mm[pc]; push(1, 0, pc, 0, "R3"); pc = pc + 1;
          push(1, 0, a, 0, "R3"); ac = mm[a]; ltag = "R3";
        end
        8'h08: begin
          a = mm[pc]; push(1, 0, pc, 0, "R4"); pc = pc + 1;
          push(0, 1, a, ac, {"R4 ", ltag}); mm[a] = ac;
        end
        8'h11: begin gr = ac; nt = "R5"; end
        8'h29: begin ac = ac - gr; z = (ac == 0); ltag = "R6"; nt = "R6"; end
        8'h40: begin ac = ac & gr; z = (ac == 0); ltag = "R7"; nt = "R7"; end
        8'h41: begin ac = ac ^ gr; z = (ac == 0); ltag = "R7"; nt = "R7"; end
        8'h60: begin push(1, 0, pc, 0, "R9"); pc = mm[pc]; nt = "R9"; end
        8'h68: begin
          push(1, 0, pc, 0, "R10");
          pc = z ? pc + 1 : mm[pc];
          nt = "R8 R10";
        end
        8'hF8: h = 1;
        default: nt = "R12";
      endcase
    end
  endtask

  task automatic poke(int a, logic [7:0] v);
    mem[a] = v;
  endtask

  task automatic hold_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    cmp("R1 cs in reset", {7'b0, cs}, 8'h00);
    cmp("R1 rd in reset", {7'b0, rd}, 8'h00);
    cmp("R1 wr in reset", {7'b0, wr}, 8'h00);
  endtask

  task automatic run(int n);
    cyc_t e;
    build(n);
    rst_n = 1'b1;
    for (int i = 0; i < n; i++) begin
      #1;
      e = exp_q.pop_front();
      cmp("R13 cs", {7'b0, cs}, {7'b0, e.r | e.w});
      cmp({e.t, " rd"}, {7'b0, rd}, {7'b0, e.r});
      cmp({e.t, " wr"}, {7'b0, wr}, {7'b0, e.w});
      if (e.r || e.w) cmp({e.t, " addr"}, addr, e.a);
      if (e.w) cmp({e.t, " data"}, bus, e.d);
      @(negedge clk);
    end
    for (int i = 0; i < 256; i++)
      if (mem[i] !== mm[i]) cmp("R4 memory image", mem[i], mm[i]);
    checks++;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'hF8;
    hold_reset();
    // program 1: all opcodes, both jnz outcomes, halt
    poke(8'h00, 8'h00); poke(8'h01, 8'h30); poke(8'h02, 8'h11);
    poke(8'h03, 8'h00); poke(8'h04, 8'h31); poke(8'h05, 8'h29);
    poke(8'h06, 8'h08); poke(8'h07, 8'h40); poke(8'h08, 8'h68);
    poke(8'h09, 8'h20); poke(8'h0A, 8'h00); poke(8'h0B, 8'h32);
    poke(8'h0C, 8'h40); poke(8'h0D, 8'h08); poke(8'h0E, 8'h41);
    poke(8'h0F, 8'h68); poke(8'h10, 8'h14); poke(8'h11, 8'hF8);
    poke(8'h14, 8'h00); poke(8'h15, 8'h33); poke(8'h16, 8'h41);
    poke(8'h17, 8'h29); poke(8'h18, 8'h08); poke(8'h19, 8'h42);
    poke(8'h1A, 8'h60); poke(8'h1B, 8'h50); poke(8'h50, 8'hFF);
    poke(8'h51, 8'h11); poke(8'h52, 8'h08); poke(8'h53, 8'h43);
    poke(8'h54, 8'hF8);
    poke(8'h30, 8'h5A); poke(8'h31, 8'h5A); poke(8'h32, 8'h3C); poke(8'h33, 8'hC3);
    run(70);
    // mid-run reset restarts from address 0
    hold_reset();
    run(12);
    hold_reset();
    run(70);
    // program 2: flag preserved across load/move/store, wrap-around subtract, pc wrap
    hold_reset();
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    poke(8'h00, 8'h00); poke(8'h01, 8'h30); poke(8'h02, 8'h11);
    poke(8'h03, 8'h41); poke(8'h04, 8'h00); poke(8'h05, 8'h31);
    poke(8'h06, 8'h11); poke(8'h07, 8'h08); poke(8'h08, 8'h40);
    poke(8'h09, 8'h68); poke(8'h0A, 8'h20); poke(8'h0B, 8'h00);
    poke(8'h0C, 8'h32); poke(8'h0D, 8'h29); poke(8'h0E, 8'h08);
    poke(8'h0F, 8'h41); poke(8'h10, 8'h68); poke(8'h11, 8'hFD);
    poke(8'hFD, 8'h07); poke(8'hFE, 8'h11); poke(8'hFF, 8'h9C);
    poke(8'h30, 8'h10); poke(8'h31, 8'h05); poke(8'h32, 8'h03);
    poke(8'h20, 8'hF8);
    run(90);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule